// File: doc/BRIEF.md
# Real-Time Clock Status Register Controller

This block keeps the eight-bit status word of a real-time clock and updates each bit from hardware events in the clock domain. Each bit follows its own rule. The alarm flag is set by a match, cleared only by writing a zero, and can be cleared automatically once a read is complete. The daylight-saving flag is controlled only by hardware. Two supply-level flags follow their inputs. The power-loss flag stays set until the first write to the time-keeping registers.

A host register port supplies a write strobe, an address, write data and a flag that shows a status read is in progress. The status word appears at address 07h. The block also gates write strobes into the temperature-compensation register window and blocks them while a conversion is busy.

Top module: `rtc_status_ctrl`

## Requirements
- R1: The status word bits, from bit 7 down to bit 0, are busy, oscillator fault, DST-adjusted, alarm, main-supply low, battery-low-85, battery-low-75 and power-loss. After reset the word is 8'h01: only the power-loss bit is set.
- R2: An alarm match sets the alarm bit (bit 4) on the next cycle. A host write to address 07h with data bit 4 at 0 clears it. With data bit 4 at 1 the write does not change it.
- R3: When an alarm match and any clear of the alarm bit happen in the same cycle, the bit ends up at 1.
- R4: When auto-clear is enabled, the alarm bit clears in the cycle after the read-in-progress flag falls. This does not happen if a match arrived while that flag was high; the bit then stays 1.
- R5: A DST-forward strobe sets the DST-adjusted bit (bit 5) and a DST-reverse strobe clears it. If both come in the same cycle, reverse wins. Host writes to any address never change the bit.
- R6: While DST enable is low, the DST-adjusted bit is 0 on the next cycle and forward strobes are ignored.
- R7: The main-supply-low bit (bit 3) equals the comparator input registered one cycle. It is forced to 0 while the part runs from the battery.
- R8: A total-power-loss strobe sets the power-loss bit (bit 0). The first host write to any address from 00h to 06h clears it, and a loss strobe in the same cycle wins. Writes to other addresses leave it set.
- R9: The busy (bit 7), battery-85 (bit 2) and battery-75 (bit 1) bits follow their inputs after one cycle. The oscillator-fault bit (bit 6) follows its input after a two-stage synchronizer. Host writes never change any of these bits.
- R10: The compensation write strobe is high for a host write to addresses 08h to 0Dh, but only while the busy bit is 0.
- R11: The read data equals the status word when the address is 07h and is 0 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| alarm_match_i | input | 1 | Alarm compare hit strobe |
| alarm_autoclr_i | input | 1 | Enable for clearing the alarm bit when a read ends |
| dst_en_i | input | 1 | Daylight-saving enable level |
| dst_fwd_i | input | 1 | DST forward event strobe |
| dst_rev_i | input | 1 | DST reverse event strobe |
| vdd_low_i | input | 1 | Main-supply undervoltage comparator |
| on_battery_i | input | 1 | Part is running from the backup battery |
| total_loss_i | input | 1 | Both supplies were lost together |
| osc_fault_i | input | 1 | Asynchronous oscillator fault |
| temp_busy_i | input | 1 | Temperature conversion running |
| bat85_low_i | input | 1 | Battery below the 85% trip |
| bat75_low_i | input | 1 | Battery below the 75% trip |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | 8 | Host register address |
| host_wdata_i | input | 8 | Host write data |
| rd_active_i | input | 1 | Status read in progress |
| rdata_o | output | 8 | Host read data |
| status_o | output | 8 | Current status word |
| comp_wr_o | output | 1 | Gated write strobe for compensation registers |

## Verification
The hardest case to reach from the ports is an alarm match that arrives while a read is in progress, with auto-clear enabled and the read then ending. In that case the bit must survive the falling edge of the read flag. A directed sequence sets up this case on purpose, and it also covers a match that lands in the same cycle as a host clear. Random stimulus holds the read flag high for runs of several cycles while alarm matches come sparsely. This creates many reads that either contain a match or do not.

// File: rtl/rtc_status_pkg.sv
package rtc_status_pkg;
  localparam int STAT_W = 8;
  localparam int ADDR_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [STAT_W-1:0] stat_t;

  localparam int B_BUSY = 7;
  localparam int B_OSCF = 6;
  localparam int B_DST  = 5;
  localparam int B_ALM  = 4;
  localparam int B_LVDD = 3;
  localparam int B_LB85 = 2;
  localparam int B_LB75 = 1;
  localparam int B_RTCF = 0;

  localparam stat_t STAT_RST = stat_t'(1) << B_RTCF;

  function automatic logic in_window(addr_t a, addr_t lo, addr_t hi);
    return (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ff <= '0;
        else        ff <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ff <= '0;
        else        ff <= {ff[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff[STAGES-1];
endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic match_i,
  input  logic host_clr_i,
  input  logic auto_en_i,
  input  logic rd_active_i,
  output logic alm_o,
  output logic read_end_o
);
  logic alm_q, rd_q, seen_q;
  logic auto_clr;

  assign read_end_o = rd_q & ~rd_active_i;
  assign auto_clr   = read_end_o & auto_en_i & ~seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q  <= 1'b0;
      rd_q   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      rd_q <= rd_active_i;
      if (match_i)                      alm_q <= 1'b1;
      else if (host_clr_i || auto_clr)  alm_q <= 1'b0;
      if (rd_active_i && match_i)       seen_q <= 1'b1;
      else if (!rd_active_i)            seen_q <= 1'b0;
    end
  end

  assign alm_o = alm_q;

  // R3
  alm_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_i |=> alm_q);
  // R2
  alm_no_host_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_i && !alm_q) |=> !alm_q);
endmodule

// File: rtl/rtc_dst_flag.sv
module rtc_dst_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic fwd_i,
  input  logic rev_i,
  output logic adj_o
);
  logic adj_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        adj_q <= 1'b0;
    else if (!en_i)    adj_q <= 1'b0;
    else if (rev_i)    adj_q <= 1'b0;
    else if (fwd_i)    adj_q <= 1'b1;
  end

  assign adj_o = adj_q;

  // R6
  dst_disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !adj_q);
  // R5
  dst_reverse_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && rev_i) |=> !adj_q);
endmodule

// File: rtl/rtc_status_ctrl.sv
module rtc_status_ctrl
  import rtc_status_pkg::*;
#(
  parameter int    OSC_SYNC   = 2,
  parameter addr_t STAT_ADDR  = 8'h07,
  parameter addr_t TIME_LO    = 8'h00,
  parameter addr_t TIME_HI    = 8'h06,
  parameter addr_t COMP_LO    = 8'h08,
  parameter addr_t COMP_HI    = 8'h0D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alarm_match_i,
  input  logic        alarm_autoclr_i,
  input  logic        dst_en_i,
  input  logic        dst_fwd_i,
  input  logic        dst_rev_i,
  input  logic        vdd_low_i,
  input  logic        on_battery_i,
  input  logic        total_loss_i,
  input  logic        osc_fault_i,
  input  logic        temp_busy_i,
  input  logic        bat85_low_i,
  input  logic        bat75_low_i,
  input  logic        host_wr_i,
  input  logic [7:0]  host_addr_i,
  input  logic [7:0]  host_wdata_i,
  input  logic        rd_active_i,
  output logic [7:0]  rdata_o,
  output logic [7:0]  status_o
  ,output logic       comp_wr_o
);
  // named internal events
  logic wr_status, alm_host_clr, time_wr, comp_hit, read_end;
  logic alm, dstadj, oscf;
  logic rtcf_q, lvdd_q, busy_q, lb85_q, lb75_q;

  assign wr_status    = host_wr_i && (host_addr_i == STAT_ADDR);
  assign alm_host_clr = wr_status && !host_wdata_i[B_ALM];
  assign time_wr      = host_wr_i && in_window(host_addr_i, TIME_LO, TIME_HI);
  assign comp_hit     = host_wr_i && in_window(host_addr_i, COMP_LO, COMP_HI);

  rtc_alarm_flag u_alarm (
    .clk        (clk),
    .rst_n      (rst_n),
    .match_i    (alarm_match_i),
    .host_clr_i (alm_host_clr),
    .auto_en_i  (alarm_autoclr_i),
    .rd_active_i(rd_active_i),
    .alm_o      (alm),
    .read_end_o (read_end)
  );

  rtc_dst_flag u_dst (
    .clk  (clk),
    .rst_n(rst_n),
    .en_i (dst_en_i),
    .fwd_i(dst_fwd_i),
    .rev_i(dst_rev_i),
    .adj_o(dstadj)
  );

  rtc_sync #(.STAGES(OSC_SYNC)) u_osc_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (osc_fault_i),
    .q_o  (oscf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rtcf_q <= STAT_RST[B_RTCF];
      lvdd_q <= 1'b0;
      busy_q <= 1'b0;
      lb85_q <= 1'b0;
      lb75_q <= 1'b0;
    end else begin
      if (total_loss_i) rtcf_q <= 1'b1;
      else if (time_wr) rtcf_q <= 1'b0;
      lvdd_q <= vdd_low_i & ~on_battery_i;
      busy_q <= temp_busy_i;
      lb85_q <= bat85_low_i;
      lb75_q <= bat75_low_i;
    end
  end

  always_comb begin
    status_o         = '0;
    status_o[B_BUSY] = busy_q;
    status_o[B_OSCF] = oscf;
    status_o[B_DST]  = dstadj;
    status_o[B_ALM]  = alm;
    status_o[B_LVDD] = lvdd_q;
    status_o[B_LB85] = lb85_q;
    status_o[B_LB75] = lb75_q;
    status_o[B_RTCF] = rtcf_q;
  end

  assign rdata_o   = (host_addr_i == STAT_ADDR) ? status_o : '0;
  assign comp_wr_o = comp_hit & ~busy_q;

  // R8
  rtcf_loss_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    total_loss_i |=> status_o[B_RTCF]);
  // R8
  rtcf_time_wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (time_wr && !total_loss_i) |=> !status_o[B_RTCF]);
  // R7
  lvdd_battery_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_battery_i |=> !status_o[B_LVDD]);
  // R4
  alm_read_end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active_i && alarm_match_i) |=> status_o[B_ALM]);
endmodule

// File: tb/rtc_status_ctrl_test.sv
`timescale 1ns/1ps
module rtc_status_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic match = 0, autoclr = 0, den = 1, fwd = 0, rev = 0, vlow = 0, batt = 0;
  logic loss = 0, osc = 0, busy = 0, b85 = 0, b75 = 0, wr = 0, rdact = 0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata, status;
  logic comp_wr;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model state
  logic e_alm = 0, e_dst = 0, e_rtcf = 1, e_lvdd = 0, e_busy = 0, e_b85 = 0, e_b75 = 0;
  logic [1:0] e_sync = 2'b00;
  logic e_rdq = 0, e_seen = 0;

  always #4 clk = ~clk;

  rtc_status_ctrl uut (
    .clk(clk), .rst_n(rst_n), .alarm_match_i(match), .alarm_autoclr_i(autoclr),
    .dst_en_i(den), .dst_fwd_i(fwd), .dst_rev_i(rev), .vdd_low_i(vlow),
    .on_battery_i(batt), .total_loss_i(loss), .osc_fault_i(osc),
    .temp_busy_i(busy), .bat85_low_i(b85), .bat75_low_i(b75),
    .host_wr_i(wr), .host_addr_i(addr), .host_wdata_i(wdata),
    .rd_active_i(rdact), .rdata_o(rdata), .status_o(status), .comp_wr_o(comp_wr)
  );

  function automatic logic [7:0] exp_word();
    return {e_busy, e_sync[1], e_dst, e_alm, e_lvdd, e_b85, e_b75, e_rtcf};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic rd_end;
    rd_end = e_rdq && !rdact;
    if (match) e_alm = 1;
    else if ((wr && addr == 8'h07 && !wdata[4]) || (rd_end && autoclr && !e_seen)) e_alm = 0;
    if (rdact && match) e_seen = 1;
    else if (!rdact) e_seen = 0;
    e_rdq = rdact;
    if (!den || rev) e_dst = 0;
    else if (fwd) e_dst = 1;
    if (loss) e_rtcf = 1;
    else if (wr && addr <= 8'h06) e_rtcf = 0;
    e_lvdd = vlow && !batt;
    e_sync = {e_sync[0], osc};
    e_busy = busy; e_b85 = b85; e_b75 = b75;
  endtask

  task automatic tick();
    logic [7:0] w;
    @(negedge clk);
    #1;
    w = exp_word();
    chk("R10 comp_wr", {7'd0, comp_wr}, {7'd0, wr && addr >= 8'h08 && addr <= 8'h0D && !w[7]});
    chk("R11 rdata", rdata, (addr == 8'h07) ? w : 8'h00);
    @(posedge clk);
    model_step();
    #1;
    w = exp_word();
    chk("R2 alarm", {7'd0, status[4]}, {7'd0, w[4]});
    chk("R5 dstadj", {7'd0, status[5]}, {7'd0, w[5]});
    chk("R7 lvdd", {7'd0, status[3]}, {7'd0, w[3]});
    chk("R8 rtcf", {7'd0, status[0]}, {7'd0, w[0]});
    chk("R9 followers", {status[7:6], status[2:1]}, {w[7:6], w[2:1]});
  endtask

  task automatic quiet();
    match = 0; fwd = 0; rev = 0; loss = 0; wr = 0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired (all requirements)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1 reset word", status, 8'h01);

    // R2: write with bit4=1 does not set; match sets; write 0 clears
    wr = 1; addr = 8'h07; wdata = 8'hFF; tick(); quiet();
    chk("R2 write-one ignored", {7'd0, status[4]}, 8'h00);
    match = 1; tick(); quiet();
    chk("R2 match sets", {7'd0, status[4]}, 8'h01);
    wr = 1; addr = 8'h07; wdata = 8'h00; tick(); quiet();
    chk("R2 write-zero clears", {7'd0, status[4]}, 8'h00);
    // R9: host write of ones ignored on hardware bits
    wr = 1; addr = 8'h07; wdata = 8'hFF; tick(); quiet();
    chk("R9 host write ignored", status & 8'hEE, 8'h00);
    // R3: set and host clear together
    match = 1; wr = 1; addr = 8'h07; wdata = 8'h00; tick(); quiet();
    chk("R3 set wins", {7'd0, status[4]}, 8'h01);
    // R4: match during read survives auto-clear
    autoclr = 1; rdact = 1; tick(); match = 1; tick(); quiet(); tick();
    rdact = 0; tick(); tick();
    chk("R4 sticky through read", {7'd0, status[4]}, 8'h01);
    rdact = 1; tick(); tick(); rdact = 0; tick();
    chk("R4 auto clear at read end", {7'd0, status[4]}, 8'h00);
    autoclr = 0;
    // R5/R6
    fwd = 1; tick(); quiet();
    chk("R5 forward sets", {7'd0, status[5]}, 8'h01);
    wr = 1; addr = 8'h02; wdata = 8'h00; tick(); quiet();
    chk("R5 time write leaves dstadj", {7'd0, status[5]}, 8'h01);
    fwd = 1; rev = 1; tick(); quiet();
    chk("R5 reverse wins", {7'd0, status[5]}, 8'h00);
    den = 0; fwd = 1; tick(); quiet();
    chk("R6 disabled ignores forward", {7'd0, status[5]}, 8'h00);
    den = 1;
    // R8
    loss = 1; tick(); quiet();
    wr = 1; addr = 8'h07; wdata = 8'h00; tick(); quiet();
    chk("R8 status write keeps rtcf", {7'd0, status[0]}, 8'h01);
    loss = 1; wr = 1; addr = 8'h06; tick(); quiet();
    chk("R8 loss beats clear", {7'd0, status[0]}, 8'h01);
    wr = 1; addr = 8'h03; tick(); quiet();
    chk("R8 time write clears", {7'd0, status[0]}, 8'h00);
    // R7
    vlow = 1; batt = 1; tick();
    chk("R7 battery mode masks", {7'd0, status[3]}, 8'h00);
    batt = 0; tick();
    chk("R7 low supply flagged", {7'd0, status[3]}, 8'h01);
    vlow = 0;
    // R10 blocked while busy
    busy = 1; tick(); wr = 1; addr = 8'h0A; #1;
    chk("R10 blocked while busy", {7'd0, comp_wr}, 8'h00);
    tick(); quiet(); busy = 0;

    // random phase
    for (int i = 0; i < 4000; i++) begin
      match = ($urandom % 10) == 0;
      autoclr = ($urandom % 2) == 0;
      if (($urandom % 5) == 0) rdact = ~rdact;
      den = ($urandom % 12) != 0;
      fwd = ($urandom % 8) == 0;
      rev = ($urandom % 8) == 0;
      vlow = ($urandom % 3) == 0;
      batt = ($urandom % 4) == 0;
      loss = ($urandom % 40) == 0;
      if (($urandom % 6) == 0) osc = ~osc;
      if (($urandom % 5) == 0) busy = ~busy;
      b85 = ($urandom % 3) == 0;
      b75 = ($urandom % 3) == 0;
      wr = ($urandom % 4) == 0;
      addr = 8'($urandom % 16);
      wdata = 8'($urandom);
      tick();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule